// File: doc/BRIEF.md
# Serial Sensor Bus Slave Interface

This block is the digital front end of a capacitive sensor readout device that shares a multi-drop serial bus with other devices. A host frames each transfer with a chip-enable line, clocks serial bits in with a bus clock, and marks the end of an instruction with a strobe. The block shifts the bits in, checks the embedded chip address against the address fixed for this instance, and acts only when the two agree.

A read instruction selects one of six external sensor channels or the internal temperature channel, together with one of three reference capacitors. It then puts the readout token on the shared data-out path and raises data-valid. Both are released as soon as chip enable falls. A write instruction carries an 8-bit payload into one of three configuration registers: gain, self-test DAC code and an auxiliary mode register. While the bus is idle, a local event can raise data-valid as an interrupt to the host. The bus inputs are asynchronous to the core clock and are resynchronised inside the block. The readout itself is represented by a digital token.

Top module: `sbus_slave`

## Requirements
- R1: After reset, dout_oe_o, dvalid_o and dout_o are 0, chan_sel_o and ref_sel_o are 0, and all three configuration outputs are 0.
- R2: Serial data is taken on each rising edge of bus_clk_i while bus_ce_i is high, MSB first. The header field order is a 4-bit chip address, then a 3-bit command, then a 3-bit channel code, then a 2-bit reference code, and the header is followed by the payload on writes.
- R3: A frame whose chip address differs from LOCAL_ADDR changes no output and never enables dout_oe_o.
- R4: A read (command 3'b001, exactly 12 bits when the bus_stb_i rising edge arrives) with channel code 0..6 and reference code 0..2 sets chan_sel_o and ref_sel_o to those codes and raises dout_oe_o and dvalid_o. While the read is active, dout_o follows sense_tok_i. Channel code 6 is the temperature channel.
- R5: A read with channel code 7 or reference code 3 is ignored: dout_oe_o stays low and both selects keep their values.
- R6: A write (command 3'b010, exactly 20 bits at the strobe) with element code 0, 1 or 2 loads the last 8 bits into gain_cfg_o, dac_cfg_o or aux_cfg_o respectively.
- R7: A write to element code 3..31, and any command other than 3'b001 or 3'b010, changes no output.
- R8: A frame whose bit count at the strobe does not match its command (12 for a read, 20 for a write) is ignored.
- R9: Deasserting bus_ce_i discards a partly received frame, so the next frame starts counting from its first bit.
- R10: When bus_ce_i falls, dout_oe_o, the read part of dvalid_o and dout_o return to 0 within a few core cycles.
- R11: While bus_ce_i is low and aux_cfg_o[0] is 1, event_i high raises dvalid_o with dout_oe_o low. The interrupt does not occur while bus_ce_i is high or while aux_cfg_o[0] is 0.
- R12: dout_o is 0 whenever dout_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_ce_i | input | 1 | Bus chip enable, frames a transfer |
| bus_stb_i | input | 1 | Strobe; its rising edge executes the received frame |
| bus_sdi_i | input | 1 | Serial data in |
| sense_tok_i | input | TOK_W | Readout token for the selected channel |
| event_i | input | 1 | Local interrupt request, core-clock synchronous |
| dout_o | output | TOK_W | Shared data-out value |
| dout_oe_o | output | 1 | Drive enable for the shared data-out |
| dvalid_o | output | 1 | Data valid / interrupt |
| chan_sel_o | output | 3 | Selected sensor channel (6 = temperature) |
| ref_sel_o | output | 2 | Selected reference capacitor |
| gain_cfg_o | output | 8 | Gain configuration register |
| dac_cfg_o | output | 8 | Self-test DAC code register |
| aux_cfg_o | output | 8 | Auxiliary mode register, bit 0 enables the interrupt |

## Verification
A bit counter that is not cleared when chip enable drops shows up in the next frame: that frame fails its length check, so a valid read produces no enable and a valid write leaves its register unchanged. A bad address comparison or field slice shows up as the wrong select code, the wrong register loaded, or an enable raised for a foreign address. Each of these is visible about four core cycles after the strobe edge reaches the pins. A read enable that outlives chip enable shows as dout_oe_o or dvalid_o still high a few cycles after bus_ce_i falls.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 3;
  localparam int CH_W    = 3;
  localparam int REF_W   = 2;
  localparam int ELEM_W  = CH_W + REF_W;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = ADDR_W + CMD_W + ELEM_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int NUM_CFG = 3;

  localparam logic [CMD_W-1:0] CMD_READ  = 3'b001;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b010;
  localparam logic [CH_W-1:0]  CH_MAX    = 3'd6;
  localparam logic [REF_W-1:0] REF_MAX   = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [CH_W-1:0]   chan;
    logic [REF_W-1:0]  refc;
  } hdr_t;

  typedef logic [NUM_CFG-1:0][DATA_W-1:0] cfg_bank_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sbus_shifter.sv
module sbus_shifter
  import sbus_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_s_i,
  input  logic               bclk_s_i,
  input  logic               stb_s_i,
  input  logic               sdi_s_i,
  output logic               commit_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [FRAME_W-1:0] shreg_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic               bclk_q, stb_q;
  logic               bclk_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;

  assign bclk_rise = bclk_s_i & ~bclk_q;
  assign commit_o  = ce_s_i & stb_s_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_s_i;
      stb_q  <= stb_s_i;
    end
  end

  // count saturates one past a full frame so an overlong frame never matches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!ce_s_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (commit_o) begin
      cnt_q <= '0;
    end else if (bclk_rise) begin
      sh_q  <= {sh_q[FRAME_W-2:0], sdi_s_i};
      cnt_q <= (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    end
  end

  assign bit_cnt_o = cnt_q;
  assign shreg_o   = sh_q;
endmodule

// File: rtl/sbus_decode.sv
module sbus_decode
  import sbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LOCAL_ADDR = 4'hA,
  parameter int                TOK_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_s_i,
  input  logic               commit_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  input  logic [FRAME_W-1:0] shreg_i,
  input  logic [TOK_W-1:0]   sense_tok_i,
  input  logic               event_i,
  output logic               read_act_o,
  output logic               irq_o,
  output logic [TOK_W-1:0]   tok_o,
  output logic [CH_W-1:0]    chan_o,
  output logic [REF_W-1:0]   ref_o,
  output cfg_bank_t          cfg_o
);
  localparam logic [CNT_W-1:0] RD_LEN = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] WR_LEN = CNT_W'(FRAME_W);

  hdr_t              hdr;
  logic [DATA_W-1:0] payload;
  logic [ELEM_W-1:0] elem;
  logic              is_short, is_full, addr_hit;
  logic              rd_ok, wr_ok;

  assign is_short = (bit_cnt_i == RD_LEN);
  assign is_full  = (bit_cnt_i == WR_LEN);
  // a read frame sits right-aligned in the shifter; a write header sits above the payload
  assign hdr      = is_short ? hdr_t'(shreg_i[HDR_W-1:0]) : hdr_t'(shreg_i[FRAME_W-1:DATA_W]);
  assign payload  = shreg_i[DATA_W-1:0];
  assign elem     = {hdr.chan, hdr.refc};
  assign addr_hit = (hdr.addr == LOCAL_ADDR);

  assign rd_ok = commit_i & addr_hit & is_short & (hdr.cmd == CMD_READ)
               & (hdr.chan <= CH_MAX) & (hdr.refc <= REF_MAX);
  assign wr_ok = commit_i & addr_hit & is_full & (hdr.cmd == CMD_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_act_o <= 1'b0;
      chan_o     <= '0;
      ref_o      <= '0;
    end else if (!ce_s_i) begin
      read_act_o <= 1'b0;
    end else if (rd_ok) begin
      read_act_o <= 1'b1;
      chan_o     <= hdr.chan;
      ref_o      <= hdr.refc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_o <= '0;
      irq_o <= 1'b0;
    end else begin
      tok_o <= sense_tok_i;
      irq_o <= ~ce_s_i & event_i & cfg_o[NUM_CFG-1][0];
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cfg_o[g] <= '0;
      else if (wr_ok && elem == ELEM_W'(g))        cfg_o[g] <= payload;
    end
  end
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LOCAL_ADDR  = 4'hA,
  parameter int                TOK_W       = 8,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_clk_i,
  input  logic             bus_ce_i,
  input  logic             bus_stb_i,
  input  logic             bus_sdi_i,
  input  logic [TOK_W-1:0] sense_tok_i,
  input  logic             event_i,
  output logic [TOK_W-1:0] dout_o,
  output logic             dout_oe_o,
  output logic             dvalid_o,
  output logic [2:0]       chan_sel_o,
  output logic [1:0]       ref_sel_o,
  output logic [7:0]       gain_cfg_o,
  output logic [7:0]       dac_cfg_o,
  output logic [7:0]       aux_cfg_o
);
  logic [3:0]         bus_s;
  logic               bclk_s, ce_s, stb_s, sdi_s;
  logic               commit;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               read_act, irq;
  logic [TOK_W-1:0]   tok;
  cfg_bank_t          cfg;

  sbus_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_clk_i, bus_ce_i, bus_stb_i, bus_sdi_i}),
    .q_o    (bus_s)
  );
  assign {bclk_s, ce_s, stb_s, sdi_s} = bus_s;

  sbus_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_s_i    (ce_s),
    .bclk_s_i  (bclk_s),
    .stb_s_i   (stb_s),
    .sdi_s_i   (sdi_s),
    .commit_o  (commit),
    .bit_cnt_o (bit_cnt),
    .shreg_o   (shreg)
  );

  sbus_decode #(.LOCAL_ADDR(LOCAL_ADDR), .TOK_W(TOK_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_s_i      (ce_s),
    .commit_i    (commit),
    .bit_cnt_i   (bit_cnt),
    .shreg_i     (shreg),
    .sense_tok_i (sense_tok_i),
    .event_i     (event_i),
    .read_act_o  (read_act),
    .irq_o       (irq),
    .tok_o       (tok),
    .chan_o      (chan_sel_o),
    .ref_o       (ref_sel_o),
    .cfg_o       (cfg)
  );

  assign dout_oe_o  = read_act;
  assign dout_o     = read_act ? tok : '0;
  assign dvalid_o   = read_act | irq;
  assign gain_cfg_o = cfg[0];
  assign dac_cfg_o  = cfg[1];
  assign aux_cfg_o  = cfg[2];
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk
  import sbus_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_s,
  input logic             commit,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             dout_oe_o,
  input logic             dvalid_o,
  input logic [2:0]       chan_sel_o,
  input logic [1:0]       ref_sel_o,
  input cfg_bank_t        cfg
);
  a_r10_oe_follows_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> $past(ce_s));

  a_r11_irq_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && !dout_oe_o) |-> !$past(ce_s));

  a_r6_cfg_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit) |-> $stable(cfg));

  a_r4_sel_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit) |-> $stable({chan_sel_o, ref_sel_o}));

  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ce_s) |-> (bit_cnt == '0));
endmodule

bind sbus_slave sbus_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_s       (ce_s),
  .commit     (commit),
  .bit_cnt    (bit_cnt),
  .dout_oe_o  (dout_oe_o),
  .dvalid_o   (dvalid_o),
  .chan_sel_o (chan_sel_o),
  .ref_sel_o  (ref_sel_o),
  .cfg        (cfg)
);

// File: tb/sbus_slave_bench.sv
module sbus_slave_bench;
  localparam int HALF  = 20;
  localparam int LIMIT = 150000;
  localparam logic [3:0] ME = 4'hA;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, ce = 1'b0, stb = 1'b0, sdi = 1'b0;
  logic [7:0] tok = 8'h00;
  logic       ev = 1'b0;
  logic [7:0] dout;
  logic       oe, dv;
  logic [2:0] chan;
  logic [1:0] refs;
  logic [7:0] gain, dac, aux;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sbus_slave u_sbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_ce_i(ce),
    .bus_stb_i(stb), .bus_sdi_i(sdi), .sense_tok_i(tok), .event_i(ev),
    .dout_o(dout), .dout_oe_o(oe), .dvalid_o(dv), .chan_sel_o(chan),
    .ref_sel_o(refs), .gain_cfg_o(gain), .dac_cfg_o(dac), .aux_cfg_o(aux)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(HALF);
      bclk = 1'b1;
      wait_clk(HALF);
      bclk = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] v, input int n);
    ce = 1'b1;
    wait_clk(HALF);
    shift_bits(v, n);
    stb = 1'b1;
    wait_clk(HALF);
    stb = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic ce_off();
    ce = 1'b0;
    wait_clk(HALF);
  endtask

  function automatic logic [31:0] rd(input logic [3:0] a, input logic [2:0] c,
                                     input logic [1:0] r);
    return {20'd0, a, 3'b001, c, r};
  endfunction

  function automatic logic [31:0] wr(input logic [3:0] a, input logic [2:0] cmd,
                                     input logic [4:0] e, input logic [7:0] d);
    return {12'd0, a, cmd, e, d};
  endfunction

  task automatic t_reset();
    check("R1", "oe", oe, 0);
    check("R1", "dvalid", dv, 0);
    check("R1", "dout", dout, 0);
    check("R1", "sel", {chan, refs}, 0);
    check("R1", "cfg", {gain, dac, aux}, 0);
  endtask

  task automatic t_read();
    tok = 8'h5C;
    send(rd(ME, 3'd5, 2'd2), 12);
    check("R2", "chan", chan, 5);
    check("R4", "ref", refs, 2);
    check("R4", "oe", oe, 1);
    check("R4", "dvalid", dv, 1);
    check("R4", "dout", dout, 8'h5C);
    tok = 8'h33;
    wait_clk(5);
    check("R4", "dout follows", dout, 8'h33);
    ce_off();
    check("R10", "oe released", oe, 0);
    check("R10", "dvalid released", dv, 0);
    check("R12", "dout gated", dout, 0);
    send(rd(ME, 3'd6, 2'd0), 12);
    check("R4", "temp chan", {chan, refs, oe}, {3'd6, 2'd0, 1'b1});
    ce_off();
  endtask

  task automatic t_read_bad();
    send(rd(ME, 3'd7, 2'd1), 12);
    check("R5", "chan 7 ignored", {oe, chan, refs}, {1'b0, 3'd6, 2'd0});
    ce_off();
    send(rd(ME, 3'd2, 2'd3), 12);
    check("R5", "ref 3 ignored", {oe, chan, refs}, {1'b0, 3'd6, 2'd0});
    ce_off();
  endtask

  task automatic t_write();
    send(wr(ME, 3'b010, 5'd0, 8'hC5), 20);
    ce_off();
    check("R6", "gain", gain, 8'hC5);
    send(wr(ME, 3'b010, 5'd1, 8'h07), 20);
    ce_off();
    check("R6", "dac", dac, 8'h07);
    send(wr(ME, 3'b010, 5'd2, 8'h01), 20);
    ce_off();
    check("R6", "aux", aux, 8'h01);
  endtask

  task automatic t_write_bad();
    send(wr(ME, 3'b010, 5'd3, 8'hFF), 20);
    ce_off();
    check("R7", "elem 3 ignored", {gain, dac, aux}, {8'hC5, 8'h07, 8'h01});
    send(wr(ME, 3'b101, 5'd0, 8'hFF), 20);
    ce_off();
    check("R7", "reserved cmd", {gain, dac, aux}, {8'hC5, 8'h07, 8'h01});
    send({20'd0, ME, 3'b000, 3'd1, 2'd1}, 12);
    check("R7", "cmd 0 no read", {oe, chan}, {1'b0, 3'd6});
    ce_off();
  endtask

  task automatic t_mismatch();
    send(rd(4'h3, 3'd1, 2'd1), 12);
    check("R3", "no oe", {oe, dv, chan, refs}, {1'b0, 1'b0, 3'd6, 2'd0});
    ce_off();
    send(wr(4'h3, 3'b010, 5'd0, 8'h11), 20);
    ce_off();
    check("R3", "no write", gain, 8'hC5);
  endtask

  task automatic t_length();
    send({13'd0, wr(ME, 3'b010, 5'd1, 8'h99)} >> 1, 19);
    ce_off();
    check("R8", "19-bit write", dac, 8'h07);
    send({rd(ME, 3'd3, 2'd1), 1'b0}, 13);
    check("R8", "13-bit read", {oe, chan}, {1'b0, 3'd6});
    ce_off();
  endtask

  task automatic t_abort();
    ce = 1'b1;
    wait_clk(HALF);
    shift_bits(32'h1F, 5);
    ce_off();
    send(rd(ME, 3'd1, 2'd1), 12);
    check("R9", "frame after abort", {oe, chan, refs}, {1'b1, 3'd1, 2'd1});
    ce_off();
  endtask

  task automatic t_irq();
    ev = 1'b1;
    wait_clk(6);
    check("R11", "irq dvalid", {dv, oe}, {1'b1, 1'b0});
    ev = 1'b0;
    wait_clk(6);
    check("R11", "irq drop", dv, 0);
    ce = 1'b1;
    wait_clk(HALF);
    ev = 1'b1;
    wait_clk(6);
    check("R11", "no irq when ce", dv, 0);
    ev = 1'b0;
    ce_off();
    send(wr(ME, 3'b010, 5'd2, 8'h00), 20);
    ce_off();
    ev = 1'b1;
    wait_clk(6);
    check("R11", "no irq when disabled", dv, 0);
    check("R12", "dout idle", dout, 0);
    ev = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_read();
    t_read_bad();
    t_write();
    t_write_bad();
    t_mismatch();
    t_length();
    t_abort();
    t_irq();
    finish_run();
  end

  initial begin
    wait_clk(LIMIT);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule